// File: doc/BRIEF.md
# One-Hot Row Select Pointer

This block drives the row-select lines of a pixel array. It holds a single active bit, one per array row, that chooses the row currently being reset or read. An advance strobe moves the active bit by one row toward the last row. A synchronization strobe puts the active bit at a start row held in a preset register. The preset register is written earlier as a binary row index.

Vertical windowing works in two steps. First the preset is set to a start row other than row 0 and a sync is issued. Then only as many advance strobes are issued as the window has rows. A shutter system uses two copies of the block, one for readout and one for reset. The row distance between the two pointers sets the exposure time. Moving past the last row leaves no row selected, and the pointer stays that way until the next sync. The row count is the parameter `NUM_ROWS`.

Top module: `row_ptr_sel`

## Requirements
- R1: While `rst_n` is low, `row_sel` is all zeros and `preset_err` is 0. The stored preset index resets to 0, so a sync issued after reset with no preset write selects row 0.
- R2: At no time is more than one bit of `row_sel` set.
- R3: When `preset_we` is high at a clock edge, `preset_idx` is stored at that edge. A sync in the same cycle as the write uses the previously stored index. The new index applies to syncs in later cycles.
- R4: When `sync_pulse` is high at a clock edge, from that edge on `row_sel` has exactly bit k set, where k is the stored index. Bit i of `row_sel` drives row i.
- R5: When `adv_pulse` is high and `sync_pulse` is low at an edge, and bit i is set with i < NUM_ROWS-1, bit i+1 is the only bit set after that edge.
- R6: An advance from the last row (bit NUM_ROWS-1) clears `row_sel` to all zeros. An advance while `row_sel` is all zeros leaves it all zeros. The pointer never wraps to row 0.
- R7: If `sync_pulse` and `adv_pulse` are both high at the same edge, the sync takes effect and the advance is ignored.
- R8: With neither strobe high at an edge, `row_sel` keeps its value.
- R9: Writing an index of NUM_ROWS or more sets `preset_err` to 1 from that edge on, until an in-range index is written, which clears it. A sync while the stored index is out of range makes `row_sel` all zeros.
- R10: After a preset to row p and a sync, each of n advances (p+n < NUM_ROWS) selects row p+n in turn. This means a window of rows p onward is scanned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| preset_we | input | 1 | Write strobe for the preset index |
| preset_idx | input | IDX_W | Binary start-row index to store |
| sync_pulse | input | 1 | Load the stored start row into the pointer |
| adv_pulse | input | 1 | Move the pointer one row toward the last row |
| row_sel | output | NUM_ROWS | One-hot row select, bit i = row i |
| preset_err | output | 1 | Stored preset index is out of range |

## Verification
The bench checks the write/sync hazard: a sync in the same cycle as a preset write must use the old index. A design that passed the new index straight through would select the wrong row. The bench also steps past the last row and then advances again. A design that wrapped, or that shifted in a fresh bit, would bring a row back to life. Sync and advance are issued together to check that sync wins. A design with the wrong priority would land one row beyond the preset. The out-of-range index with the default of 12 rows (a 4-bit index) must select nothing and raise the flag. A decoder that truncated or aliased the index would select a real row.

// File: rtl/rowptr_pkg.sv
package rowptr_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_LOAD = 2'd1,
    PTR_STEP = 2'd2
  } ptr_cmd_e;

  // sync outranks advance
  function automatic ptr_cmd_e resolve_cmd(input logic sync_i, input logic adv_i);
    if (sync_i)     return PTR_LOAD;
    else if (adv_i) return PTR_STEP;
    else            return PTR_HOLD;
  endfunction

endpackage

// File: rtl/row_preset_reg.sv
module row_preset_reg #(
  parameter int NUM_ROWS = 12,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] idx_q,
  output logic             err_q
);

  logic [IDX_W-1:0] idx_d;
  logic             err_d;
  logic             wr_bad;

  assign wr_bad = (int'(wr_idx) >= NUM_ROWS);

  always_comb begin
    idx_d = idx_q;
    err_d = err_q;
    if (wr_en) begin
      idx_d = wr_idx;
      err_d = wr_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/row_onehot_dec.sv
module row_onehot_dec #(
  parameter int NUM_ROWS = 12,
  parameter int IDX_W    = 4
) (
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_ROWS-1:0] onehot
);

  // Indices with no matching row decode to all zeros
  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_dec
    localparam logic [IDX_W-1:0] ROW_CODE = IDX_W'(g);
    assign onehot[g] = (idx == ROW_CODE);
  end

endmodule

// File: rtl/row_shift_core.sv
module row_shift_core
  import rowptr_pkg::*;
#(
  parameter int NUM_ROWS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ptr_cmd_e            cmd,
  input  logic [NUM_ROWS-1:0] load_vec,
  output logic [NUM_ROWS-1:0] row_q
);

  logic [NUM_ROWS-1:0] row_d;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_stage
    logic from_prev;
    if (g == 0) begin : g_first
      assign from_prev = 1'b0;   // nothing shifts into row 0: no wrap
    end else begin : g_rest
      assign from_prev = row_q[g-1];
    end

    always_comb begin
      unique case (cmd)
        PTR_LOAD: row_d[g] = load_vec[g];
        PTR_STEP: row_d[g] = from_prev;
        default:  row_d[g] = row_q[g];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

endmodule

// File: rtl/row_ptr_sel.sv
module row_ptr_sel
  import rowptr_pkg::*;
#(
  parameter int NUM_ROWS = 12,
  localparam int IDX_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                preset_we,
  input  logic [IDX_W-1:0]    preset_idx,
  input  logic                sync_pulse,
  input  logic                adv_pulse,
  output logic [NUM_ROWS-1:0] row_sel,
  output logic                preset_err
);

  logic [IDX_W-1:0]    stored_idx;
  logic [NUM_ROWS-1:0] start_vec;
  ptr_cmd_e            cmd;

  assign cmd = resolve_cmd(sync_pulse, adv_pulse);

  row_preset_reg #(.NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)) u_preset (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (preset_we),
    .wr_idx (preset_idx),
    .idx_q  (stored_idx),
    .err_q  (preset_err)
  );

  row_onehot_dec #(.NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)) u_dec (
    .idx    (stored_idx),
    .onehot (start_vec)
  );

  row_shift_core #(.NUM_ROWS(NUM_ROWS)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .load_vec (start_vec),
    .row_q    (row_sel)
  );

endmodule

// File: rtl/row_ptr_sel_chk.sv
module row_ptr_sel_chk #(
  parameter int NUM_ROWS = 12,
  parameter int IDX_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                preset_we,
  input logic [IDX_W-1:0]    preset_idx,
  input logic                sync_pulse,
  input logic                adv_pulse,
  input logic [NUM_ROWS-1:0] row_sel,
  input logic                preset_err
);

  assert_onehot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_pulse && !sync_pulse) |=> (row_sel == ($past(row_sel) << 1)));

  assert_no_revive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_pulse && row_sel == '0) |=> (row_sel == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_pulse && !adv_pulse) |=> $stable(row_sel));

  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_we && int'(preset_idx) >= NUM_ROWS) |=> preset_err);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_we && int'(preset_idx) < NUM_ROWS) |=> !preset_err);

  assert_bad_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && preset_err) |=> (row_sel == '0));

  assert_good_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && !preset_err) |=> $onehot(row_sel));

endmodule

bind row_ptr_sel row_ptr_sel_chk #(.NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .preset_we  (preset_we),
  .preset_idx (preset_idx),
  .sync_pulse (sync_pulse),
  .adv_pulse  (adv_pulse),
  .row_sel    (row_sel),
  .preset_err (preset_err)
);

// File: tb/test_row_ptr_sel.sv
module test_row_ptr_sel;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 12;
  localparam int IW = 4;

  logic            clk;
  logic            rst_n;
  logic            preset_we;
  logic [IW-1:0]   preset_idx;
  logic            sync_pulse;
  logic            adv_pulse;
  logic [ROWS-1:0] row_sel;
  logic            preset_err;

  int n_checks = 0;
  int n_errors = 0;

  row_ptr_sel #(.NUM_ROWS(ROWS)) i_row_ptr_sel (
    .clk(clk), .rst_n(rst_n), .preset_we(preset_we), .preset_idx(preset_idx),
    .sync_pulse(sync_pulse), .adv_pulse(adv_pulse),
    .row_sel(row_sel), .preset_err(preset_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [ROWS-1:0] row_bit(input int r);
    logic [ROWS-1:0] v = '0;
    if (r >= 0 && r < ROWS) v[r] = 1'b1;
    return v;
  endfunction

  task automatic chk_vec(input string req, input logic [ROWS-1:0] act, input logic [ROWS-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: row_sel actual=%b expected=%b", req, act, exp);
    end
    n_checks++;
    if ($countones(act) > 1) begin
      n_errors++;
      $display("FAIL R2: row_sel actual=%b expected at most one bit", act);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: preset_err actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 after posedge
  task automatic step(input logic we, input int idx, input logic sy, input logic ad);
    @(negedge clk);
    preset_we = we; preset_idx = IW'(idx); sync_pulse = sy; adv_pulse = ad;
    @(posedge clk); #1;
    preset_we = 1'b0; sync_pulse = 1'b0; adv_pulse = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; preset_we = 0; preset_idx = '0; sync_pulse = 0; adv_pulse = 0;
    repeat (3) @(posedge clk);
    #1;
    chk_vec("R1 reset row_sel", row_sel, '0);
    chk_bit("R1 reset err", preset_err, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 1, 0);
    chk_vec("R1 reset preset index 0", row_sel, row_bit(0));
  endtask

  task automatic t_load_scan;
    step(1, 3, 0, 0);
    step(0, 0, 1, 0);
    chk_vec("R4 sync to row 3", row_sel, row_bit(3));
    for (int k = 1; k <= 3; k++) begin
      step(0, 0, 0, 1);
      chk_vec("R5 advance", row_sel, row_bit(3 + k));
    end
  endtask

  task automatic t_window;
    step(1, 5, 0, 0);
    step(0, 0, 1, 0);
    chk_vec("R10 window start", row_sel, row_bit(5));
    for (int k = 1; k <= 4; k++) begin
      step(0, 0, 0, 1);
      chk_vec("R10 window row", row_sel, row_bit(5 + k));
    end
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 0);
      chk_vec("R8 hold", row_sel, row_bit(9));
    end
  endtask

  task automatic t_last_row;
    step(1, ROWS - 1, 0, 0);
    step(0, 0, 1, 0);
    chk_vec("R4 sync last row", row_sel, row_bit(ROWS - 1));
    step(0, 0, 0, 1);
    chk_vec("R6 past last row", row_sel, '0);
    step(0, 0, 0, 1);
    chk_vec("R6 advance from empty", row_sel, '0);
    step(0, 0, 0, 1);
    chk_vec("R6 no wrap", row_sel, '0);
  endtask

  task automatic t_priority;
    step(1, 2, 1, 0);  // sync uses old index (last row)
    chk_vec("R3 same-cycle write uses old index", row_sel, row_bit(ROWS - 1));
    step(0, 0, 1, 0);
    chk_vec("R3 new index used later", row_sel, row_bit(2));
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    chk_vec("R5 moved to row 4", row_sel, row_bit(4));
    step(0, 0, 1, 1);
    chk_vec("R7 sync beats advance", row_sel, row_bit(2));
  endtask

  task automatic t_bad_index;
    step(1, 13, 0, 0);
    chk_bit("R9 err raised", preset_err, 1'b1);
    chk_vec("R9 write alone keeps row", row_sel, row_bit(2));
    step(0, 0, 1, 0);
    chk_vec("R9 sync out of range", row_sel, '0);
    chk_bit("R9 err held", preset_err, 1'b1);
    step(1, ROWS, 1, 0);
    chk_vec("R9 index equal to row count", row_sel, '0);
    step(1, 4, 0, 0);
    chk_bit("R9 err cleared", preset_err, 1'b0);
    step(0, 0, 1, 0);
    chk_vec("R9 sync after recovery", row_sel, row_bit(4));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load_scan();
    t_window();
    t_last_row();
    t_priority();
    t_bad_index();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule